// File: doc/BRIEF.md
# Channel Health Status and Interrupt Monitor

This block watches the health of a bank of sensor channels. For each channel it gets three digital flags from the analog front end: the signal is present, the excitation is present, and the built-in accuracy test currently passes. It turns these flags into three per-channel status registers, a latched interrupt status register and one interrupt line. Software reaches everything through a small register port.

Status bits read 1 for a healthy channel and 0 for a failed one. A failure latches its 0 until software reads that register. After the read, the bit follows the live condition again. A signal or excitation loss counts only after it has lasted a programmable number of clock cycles. Channels that are not in the active mask always report 0 and never raise an interrupt. While either of the two initiated test modes is on, signal and excitation monitoring is suspended.

Register addresses (addr_i): 0 active mask (read/write), 1 interrupt enable (read/write), 2 interrupt status (read, cleared by the read), 3 signal status, 4 excitation status, 5 test status, 6 test mode (read/write). Reads are combinational: rdata_o is valid while rd_en_i is high. The side effect of a read takes place at the clock edge that ends the read cycle. When no read is under way, rdata_o is 0.

Top module: `chan_health_mon`

## Requirements
- R1: Registers 3, 4 and 5 hold signal, excitation and test status, with channel n on bit n. 1 means OK and 0 means loss or failure. Bits at and above NUM_CH read 0.
- R2: A channel whose bit in the active mask (register 0, reset value 0) is 0 reads 0 in all three status registers and never causes an interrupt.
- R3: A signal or excitation loss on an active channel counts only once it has been present on PERSIST_CYC consecutive clock edges. Before that, the status bit still reads 1.
- R4: A counted failure keeps its status bit at 0 until that status register is read. After the read, the bit shows the live condition.
- R5: If a loss condition goes away before the timeout, that channel's persistence count restarts from zero.
- R6: Interrupt enable and interrupt status share one layout: bit 0 is signal loss, bit 1 is excitation loss, bit 3 is test accuracy error, and bit 2 reads 0. A status bit sets only when its event occurs while its enable bit is 1. Reading register 2 clears it, so a second read returns 0.
- R7: While test-mode bit 3 (initiated self-test) or bit 0 (interface test) is 1, no signal or excitation loss is counted, reported or signalled.
- R8: irq_o is high exactly when any interrupt status bit is set. It drops after register 2 has been read, unless a new event arrived in that same cycle. It is 0 after reset.
- R9: When a new failure event and the read that clears it fall in the same cycle, the event wins and stays latched.
- R10: A test failure on an active channel latches at once, with no persistence filter, even if it lasts one cycle. Its interrupt event occurs when the failure starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_ok_i | input | NUM_CH | Per-channel signal-present flag |
| exc_ok_i | input | NUM_CH | Per-channel excitation-present flag |
| bit_ok_i | input | NUM_CH | Per-channel built-in test pass flag |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid while rd_en_i is high |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with NUM_CH = 8, DATA_W = 16 and PERSIST_CYC = 8. A persistence window of eight cycles makes the exact boundary reachable within a few reads: one cycle before confirmation, the confirming edge, and a loss that drops out one cycle before the limit and then restarts. Only four channels are made active while the inactive four sit in permanent loss, so the masking is exercised on every read. Both test-mode bits are held long enough to exceed the window several times over.

// File: rtl/chm_pkg.sv
package chm_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_MASK = 3'd0;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_ISTS = 3'd2;
    localparam logic [ADDR_W-1:0] A_SIG  = 3'd3;
    localparam logic [ADDR_W-1:0] A_EXC  = 3'd4;
    localparam logic [ADDR_W-1:0] A_TST  = 3'd5;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd6;

    // interrupt layout
    localparam int IRQ_W   = 4;
    localparam int IRQ_SIG = 0;
    localparam int IRQ_EXC = 1;
    localparam int IRQ_TST = 3;
    localparam logic [IRQ_W-1:0] IRQ_USED = 4'b1011;

    // test-mode bits
    localparam int MODE_IFT  = 0;
    localparam int MODE_SELF = 3;

    // status register kinds, in address order from A_SIG
    localparam int NUM_KINDS = 3;
endpackage

// File: rtl/chm_loss_filter.sv
module chm_loss_filter #(
    parameter int PERSIST_CYC = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loss_i,
    output logic confirm_o,
    output logic event_o
);
    localparam int CNT_W = $clog2(PERSIST_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(PERSIST_CYC);
    localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(PERSIST_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!loss_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign confirm_o = loss_i && (st_q.cnt == LIMIT);
    assign event_o   = loss_i && (st_q.cnt == LIMIT_M1);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIMIT);

    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !loss_i |=> (st_q.cnt == '0));

    a_r3_confirm_after_count: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> (st_q.cnt == LIMIT));
endmodule

// File: rtl/chm_sticky.sv
module chm_sticky #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] fail_i,
    input  logic [NUM_CH-1:0] active_i,
    input  logic              clear_i,
    output logic [NUM_CH-1:0] view_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] fail;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // a fresh failure beats a clearing read in the same cycle
        st_d.fail = fail_i | (st_q.fail & {NUM_CH{~clear_i}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign view_o = active_i & ~(st_q.fail | fail_i);

    a_r4_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((st_q.fail & $past(st_q.fail)) == $past(st_q.fail)));

    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> ((st_q.fail & $past(fail_i)) == $past(fail_i)));
endmodule

// File: rtl/chan_health_mon.sv
module chan_health_mon
    import chm_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int DATA_W      = 16,
    parameter int PERSIST_CYC = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] sig_ok_i,
    input  logic [NUM_CH-1:0] exc_ok_i,
    input  logic [NUM_CH-1:0] bit_ok_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [2:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        logic [IRQ_W-1:0]  ien;
        logic [IRQ_W-1:0]  ists;
        logic              self_test;
        logic              if_test;
        logic [NUM_CH-1:0] tst_prev;
    } regs_t;

    regs_t r_d, r_q;

    logic                                suspend;
    logic [NUM_CH-1:0]                   sig_raw, exc_raw, tst_fail;
    logic [NUM_CH-1:0]                   sig_conf, exc_conf;
    logic [NUM_CH-1:0]                   sig_evt, exc_evt, tst_evt;
    logic [NUM_KINDS-1:0][NUM_CH-1:0]    fail_now;
    logic [NUM_KINDS-1:0][NUM_CH-1:0]    view;
    logic [NUM_KINDS-1:0]                clr;
    logic [IRQ_W-1:0]                    evt;
    logic                                ists_clr;
    logic                                unused_wbits;

    assign unused_wbits = ^wdata_i;

    assign suspend  = r_q.self_test | r_q.if_test;
    assign sig_raw  = r_q.mask & ~sig_ok_i & {NUM_CH{~suspend}};
    assign exc_raw  = r_q.mask & ~exc_ok_i & {NUM_CH{~suspend}};
    assign tst_fail = r_q.mask & ~bit_ok_i;
    assign tst_evt  = tst_fail & ~r_q.tst_prev;

    // per-channel persistence filters
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chm_loss_filter #(.PERSIST_CYC(PERSIST_CYC)) u_sig_flt (
            .clk       (clk),
            .rst_n     (rst_n),
            .loss_i    (sig_raw[c]),
            .confirm_o (sig_conf[c]),
            .event_o   (sig_evt[c])
        );
        chm_loss_filter #(.PERSIST_CYC(PERSIST_CYC)) u_exc_flt (
            .clk       (clk),
            .rst_n     (rst_n),
            .loss_i    (exc_raw[c]),
            .confirm_o (exc_conf[c]),
            .event_o   (exc_evt[c])
        );
    end

    assign fail_now[0] = sig_conf;
    assign fail_now[1] = exc_conf;
    assign fail_now[2] = tst_fail;

    // one sticky status register per kind, addressed from A_SIG upward
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        assign clr[k] = rd_en_i && (addr_i == (A_SIG + ADDR_W'(k)));
        chm_sticky #(.NUM_CH(NUM_CH)) u_stk (
            .clk      (clk),
            .rst_n    (rst_n),
            .fail_i   (fail_now[k]),
            .active_i (r_q.mask),
            .clear_i  (clr[k]),
            .view_o   (view[k])
        );
    end

    assign ists_clr = rd_en_i && (addr_i == A_ISTS);

    always_comb begin
        evt          = '0;
        evt[IRQ_SIG] = |sig_evt;
        evt[IRQ_EXC] = |exc_evt;
        evt[IRQ_TST] = |tst_evt;
    end

    always_comb begin
        r_d          = r_q;
        r_d.tst_prev = tst_fail;
        r_d.ists     = (r_q.ists & {IRQ_W{~ists_clr}}) | (evt & r_q.ien);
        if (wr_en_i) begin
            case (addr_i)
                A_MASK:  r_d.mask = wdata_i[NUM_CH-1:0];
                A_IEN:   r_d.ien  = wdata_i[IRQ_W-1:0] & IRQ_USED;
                A_MODE: begin
                    r_d.self_test = wdata_i[MODE_SELF];
                    r_d.if_test   = wdata_i[MODE_IFT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            case (addr_i)
                A_MASK:  rdata_o = DATA_W'(r_q.mask);
                A_IEN:   rdata_o = DATA_W'(r_q.ien);
                A_ISTS:  rdata_o = DATA_W'(r_q.ists);
                A_SIG:   rdata_o = DATA_W'(view[0]);
                A_EXC:   rdata_o = DATA_W'(view[1]);
                A_TST:   rdata_o = DATA_W'(view[2]);
                A_MODE: begin
                    rdata_o[MODE_SELF] = r_q.self_test;
                    rdata_o[MODE_IFT]  = r_q.if_test;
                end
                default: rdata_o = '0;
            endcase
        end
    end

    assign irq_o = |r_q.ists;

    a_r2_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (addr_i == A_SIG || addr_i == A_EXC || addr_i == A_TST))
            |-> ((rdata_o[NUM_CH-1:0] & ~r_q.mask) == '0));

    a_r7_no_loss_in_test: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |-> (sig_evt == '0 && exc_evt == '0));

    a_r8_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ists_clr && evt == '0) |=> !irq_o);

    a_r6_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.ien[IRQ_SIG] && !r_q.ists[IRQ_SIG]) |=> !r_q.ists[IRQ_SIG]);

    a_r6_bit2_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.ists[2]);
endmodule

// File: tb/chan_health_mon_tb.sv
module chan_health_mon_tb;
    localparam int NCH = 8;
    localparam int DW  = 16;
    localparam int P   = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] sig_ok = 8'h0F;
    logic [NCH-1:0] exc_ok = 8'h0F;
    logic [NCH-1:0] bit_ok = 8'h0F;
    logic           rd_en = 1'b0;
    logic           wr_en = 1'b0;
    logic [2:0]     addr = 3'd0;
    logic [DW-1:0]  wdata = '0;
    logic [DW-1:0]  rdata;
    logic           irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // 50 MHz: 20 time units per period
    always #10 clk = ~clk;

    chan_health_mon #(.NUM_CH(NCH), .DATA_W(DW), .PERSIST_CYC(P)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .sig_ok_i(sig_ok), .exc_ok_i(exc_ok), .bit_ok_i(bit_ok),
        .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // reads over exactly one clock edge, starting at the current negedge
    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        rd_en = 1'b1; addr = a;
        #2 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_expect(input logic [2:0] a, input logic [DW-1:0] exp, input string req);
        logic [DW-1:0] v;
        rd(a, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic t_reset();
        check(irq == 1'b0, "R8 reset irq", irq, 0);
        rd_expect(3'd3, 16'h0000, "R2 reset sig");
        rd_expect(3'd5, 16'h0000, "R2 reset tst");
        rd_expect(3'd2, 16'h0000, "R6 reset ists");
    endtask

    task automatic t_setup();
        wr(3'd0, 16'h000F);
        wr(3'd1, 16'h000F);
        rd_expect(3'd1, 16'h000B, "R6 enable layout");
        rd_expect(3'd3, 16'h000F, "R1 sig all ok");
        rd_expect(3'd4, 16'h000F, "R1 exc all ok");
        rd_expect(3'd5, 16'h000F, "R1 tst all ok");
    endtask

    task automatic t_restart();
        sig_ok[2] = 1'b0; tick(P - 1);
        sig_ok[2] = 1'b1; tick(1);
        sig_ok[2] = 1'b0; tick(P - 1);
        sig_ok[2] = 1'b1;
        check(irq == 1'b0, "R5 no irq after restart", irq, 0);
        rd_expect(3'd3, 16'h000F, "R5 sig still ok");
    endtask

    task automatic t_persist();
        sig_ok[1] = 1'b0; tick(P - 1);
        check(irq == 1'b0, "R3 irq before limit", irq, 0);
        rd_expect(3'd3, 16'h000F, "R3 sig before limit");
        check(irq == 1'b1, "R8 irq at limit", irq, 1);
        rd_expect(3'd3, 16'h000D, "R3 sig after limit");
        sig_ok[1] = 1'b1;
        rd_expect(3'd3, 16'h000D, "R4 latched after recovery");
        rd_expect(3'd3, 16'h000F, "R4 released after read");
        rd_expect(3'd2, 16'h0001, "R6 sig irq bit");
        check(irq == 1'b0, "R8 irq after clear", irq, 0);
        rd_expect(3'd2, 16'h0000, "R6 second read zero");
    endtask

    task automatic t_exc();
        exc_ok[0] = 1'b0; tick(P);
        rd_expect(3'd2, 16'h0002, "R6 exc irq bit");
        exc_ok[0] = 1'b1;
        rd_expect(3'd4, 16'h000E, "R1 exc bit0 latched");
        rd_expect(3'd4, 16'h000F, "R4 exc released");
    endtask

    task automatic t_test_transient();
        bit_ok[3] = 1'b0; tick(1);
        bit_ok[3] = 1'b1;
        rd_expect(3'd5, 16'h0007, "R10 one-cycle test fail latched");
        rd_expect(3'd5, 16'h000F, "R10 test released");
        rd_expect(3'd2, 16'h0008, "R6 test irq bit");
    endtask

    task automatic t_masked_enable();
        wr(3'd1, 16'h000A);
        sig_ok[0] = 1'b0; tick(2 * P);
        check(irq == 1'b0, "R6 disabled no irq", irq, 0);
        rd_expect(3'd2, 16'h0000, "R6 disabled no status");
        rd_expect(3'd3, 16'h000E, "R1 sig bit0 loss");
        sig_ok[0] = 1'b1;
        rd_expect(3'd3, 16'h000E, "R4 sig bit0 held");
        rd_expect(3'd3, 16'h000F, "R4 sig bit0 released");
        wr(3'd1, 16'h000B);
    endtask

    task automatic t_suspend(input logic [DW-1:0] mode, input string tag);
        wr(3'd6, mode);
        rd_expect(3'd6, mode, tag);
        sig_ok[0] = 1'b0; exc_ok[1] = 1'b0; tick(3 * P);
        rd_expect(3'd3, 16'h000F, tag);
        rd_expect(3'd4, 16'h000F, tag);
        check(irq == 1'b0, tag, irq, 0);
        sig_ok[0] = 1'b1; exc_ok[1] = 1'b1;
        wr(3'd6, 16'h0000);
        tick(2 * P);
        check(irq == 1'b0, tag, irq, 0);
    endtask

    task automatic t_collision();
        logic [DW-1:0] v;
        bit_ok[2] = 1'b0;
        rd(3'd2, v);
        check(v == 16'h0000, "R9 ists before event", v, 0);
        check(irq == 1'b1, "R9 event wins irq", irq, 1);
        rd_expect(3'd2, 16'h0008, "R9 event kept");
        bit_ok[2] = 1'b1;
        rd_expect(3'd5, 16'h000B, "R10 test bit2 held");
        rd_expect(3'd5, 16'h000F, "R10 test bit2 released");
    endtask

    task automatic t_inactive();
        tick(4 * P);
        rd_expect(3'd3, 16'h000F, "R2 inactive sig zero");
        rd_expect(3'd4, 16'h000F, "R2 inactive exc zero");
        check(irq == 1'b0, "R2 inactive no irq", irq, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_setup();
        t_restart();
        t_persist();
        t_exc();
        t_test_transient();
        t_masked_enable();
        t_suspend(16'h0008, "R7 self-test suspend");
        t_suspend(16'h0001, "R7 interface-test suspend");
        t_collision();
        t_inactive();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule